// File: doc/BRIEF.md
# Parallel ADC conversion sequencer

This block is the host side of a handshake with a 16-bit successive-approximation converter whose result comes out on a parallel bus. A single-cycle sample request makes the block start a conversion. It first drives the read/convert line low and then pulls chip-select low. It waits until the converter's busy line goes low and then high again. It then switches read/convert high, which enables the converter's output bus, and captures the word. Finally it returns both lines to idle well inside the short window the converter allows after busy rises, so that the converter does not start a second conversion with no time for acquisition.

The captured word leaves the block as a signed code together with a one-cycle valid pulse and a running sample count. Requests that arrive while a sequence is active are dropped and counted as overruns. If the converter never completes a conversion, a timeout abandons the sequence and reports the fault.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While rst_ni is low and after reset, cs_no and rc_o are 1, and valid_o, overrun_o, timeout_o, sample_cnt_o and overrun_cnt_o are 0.
- R2: A request accepted in idle drives rc_o to 0 one cycle before cs_no falls. cs_no only falls while rc_o is 0 and was 0 in the cycle before.
- R3: rc_o never falls while cs_no is 0.
- R4: After busy_i rises while cs_no and rc_o are both 0, one of them returns to 1 within REL_CYC clock cycles. REL_CYC is the integer part of RELEASE_NS times CLK_HZ divided by 1e9, which is 12 by default.
- R5: busy_i passes through a two-flop synchronizer. The bus is sampled one cycle after the synchronized rising edge, in a cycle where cs_no is 0 and rc_o is 1, and sample_o equals the value of data_i in that cycle.
- R6: valid_o is a one-cycle pulse. In the cycle it is high, cs_no and rc_o are both 1 again.
- R7: sample_cnt_o increases by one with each valid_o pulse and holds its value otherwise.
- R8: A request made while a sequence is active does not affect the sequence in progress and starts no extra conversion. In the next cycle it raises overrun_o for one cycle and increments overrun_cnt_o.
- R9: If the sequence has not finished within TIMEOUT_CYC cycles of cs_no falling, timeout_o pulses for one cycle, cs_no and rc_o return to 1, and no valid_o is produced.
- R10: sample_o is a two's-complement signed code whose bit 15 is the sign and the most significant bit. For example, 16'h8000 reads as the most negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Sample request, one-cycle pulse |
| busy_i | input | 1 | Converter busy, low while converting, asynchronous |
| data_i | input | 16 | Converter parallel output bus |
| cs_no | output | 1 | Converter chip-select, active low |
| rc_o | output | 1 | Read/convert select: 1 selects read, 0 selects convert |
| valid_o | output | 1 | One-cycle pulse, new sample on sample_o |
| sample_o | output | 16 | Captured signed conversion code |
| sample_cnt_o | output | CNT_W | Number of samples delivered |
| overrun_o | output | 1 | Pulse when a request was dropped |
| overrun_cnt_o | output | CNT_W | Number of dropped requests |
| timeout_o | output | 1 | Pulse when a conversion was abandoned |

## Verification
The assertions assume the following about busy_i. It changes only after the block has started a conversion. Each fall is followed by a rise. Between these it does not toggle faster than the synchronizer can follow. They also assume data_i is stable during the cycle in which the read bus is enabled. The bench's behavioural converter keeps to these assumptions. It lowers busy only on a falling chip-select while convert is selected. It holds busy low for a fixed 100 cycles. It drives a fixed word while the read bus is enabled, and a distinct filler word otherwise. The converter can also be made to ignore starts, which produces the timeout case. It flags any case where chip-select and read/convert are left low too long after busy rises.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_STROBE,
    ST_CONV,
    ST_READ
  } seq_state_e;

  function automatic int ns_to_cycles(input longint ns, input longint hz);
    return int'((ns * hz) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  // one extra stage holds the previous synchronized value for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {(STAGES+1){RST_VAL}};
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign q_o    = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/adc_seq_cnt.sv
module adc_seq_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic busy_rise_i,
  input  logic busy_fall_i,
  output logic cs_no,
  output logic rc_o,
  output logic capture_o,
  output logic overrun_o,
  output logic timeout_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  seq_state_e state_q, state_d;
  logic [TW-1:0] tmo_q;
  logic tmo_hit, active;

  assign active  = (state_q == ST_STROBE) || (state_q == ST_CONV);
  assign tmo_hit = active && (tmo_q == TW'(TIMEOUT_CYC - 1));

  always_comb begin
    state_d   = state_q;
    capture_o = 1'b0;
    timeout_o = 1'b0;
    overrun_o = req_i && (state_q != ST_IDLE);
    unique case (state_q)
      ST_IDLE:   if (req_i) state_d = ST_ARM;
      ST_ARM:    state_d = ST_STROBE;
      ST_STROBE: begin
        if (busy_fall_i) state_d = ST_CONV;
        else if (tmo_hit) begin
          state_d   = ST_IDLE;
          timeout_o = 1'b1;
        end
      end
      ST_CONV: begin
        if (busy_rise_i) state_d = ST_READ;
        else if (tmo_hit) begin
          state_d   = ST_IDLE;
          timeout_o = 1'b1;
        end
      end
      ST_READ: begin
        capture_o = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmo_q   <= '0;
      cs_no   <= 1'b1;
      rc_o    <= 1'b1;
    end else begin
      state_q <= state_d;
      tmo_q   <= active ? tmo_q + TW'(1) : '0;
      // control lines registered from the next state: glitch-free pins
      cs_no   <= !(state_d == ST_STROBE || state_d == ST_CONV || state_d == ST_READ);
      rc_o    <= !(state_d == ST_ARM || state_d == ST_STROBE || state_d == ST_CONV);
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter int CLK_HZ      = 50_000_000,
  parameter int RELEASE_NS  = 250,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     busy_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic                     cs_no,
  output logic                     rc_o,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] sample_o,
  output logic [CNT_W-1:0]         sample_cnt_o,
  output logic                     overrun_o,
  output logic [CNT_W-1:0]         overrun_cnt_o,
  output logic                     timeout_o
);
  localparam int REL_CYC = ns_to_cycles(longint'(RELEASE_NS), longint'(CLK_HZ));

  logic busy_s, busy_rise, busy_fall;
  logic capture, overrun_p, timeout_p;

  adc_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (busy_i),
    .q_o    (busy_s),
    .rise_o (busy_rise),
    .fall_o (busy_fall)
  );

  adc_seq_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .busy_rise_i (busy_rise),
    .busy_fall_i (busy_fall),
    .cs_no       (cs_no),
    .rc_o        (rc_o),
    .capture_o   (capture),
    .overrun_o   (overrun_p),
    .timeout_o   (timeout_p)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      sample_o  <= '0;
      overrun_o <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      valid_o   <= capture;
      overrun_o <= overrun_p;
      timeout_o <= timeout_p;
      if (capture) sample_o <= $signed(data_i);
    end
  end

  adc_seq_cnt #(.W(CNT_W)) u_smp_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (capture),
    .cnt_o  (sample_cnt_o)
  );

  adc_seq_cnt #(.W(CNT_W)) u_ovr_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (overrun_p),
    .cnt_o  (overrun_cnt_o)
  );

  logic unused_busy_s;
  assign unused_busy_s = busy_s;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  parameter int REL_CYC = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_i,
  input logic [DATA_W-1:0] data_i,
  input logic              cs_no,
  input logic              rc_o,
  input logic              valid_o,
  input logic [DATA_W-1:0] sample_o,
  input logic [CNT_W-1:0]  sample_cnt_o,
  input logic              overrun_o,
  input logic              timeout_o
);
  localparam int RW = $clog2(REL_CYC + 2) + 1;

  logic busy_q;
  logic [RW-1:0] rel_cnt;

  // cycles spent with both lines low after busy rose
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b1;
      rel_cnt <= '0;
    end else begin
      busy_q <= busy_i;
      if (busy_i && !cs_no && !rc_o && (!busy_q || rel_cnt != '0))
        rel_cnt <= rel_cnt + RW'(1);
      else
        rel_cnt <= '0;
    end
  end

  a_r1_reset_lines: assert property (@(posedge clk_i) !rst_ni |=> cs_no && rc_o && !valid_o);
  a_r2_start_in_convert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !rc_o && $past(!rc_o));
  a_r3_no_convert_while_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rc_o) |-> cs_no);
  a_r4_release_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_cnt <= RW'(REL_CYC));
  a_r5_read_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(!cs_no && rc_o));
  a_r5_sample_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sample_o == $past(data_i));
  a_r6_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r6_idle_at_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cs_no && rc_o);
  a_r7_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sample_cnt_o == $past(sample_cnt_o) + CNT_W'(1));
  a_r7_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_cnt_o));
  a_r8_overrun_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(req_i) && !$past(cs_no && rc_o));
  a_r9_timeout_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> cs_no && rc_o && !valid_o);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W),
  .REL_CYC(REL_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .busy_i       (busy_i),
  .data_i       (data_i),
  .cs_no        (cs_no),
  .rc_o         (rc_o),
  .valid_o      (valid_o),
  .sample_o     (sample_o),
  .sample_cnt_o (sample_cnt_o),
  .overrun_o    (overrun_o),
  .timeout_o    (timeout_o)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int CONV_CYC = 100;
  localparam int TMO      = 400;
  localparam int NVEC     = 8;
  localparam logic [15:0] VEC [NVEC] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF,
                                         16'h1234, 16'hA5A5, 16'h0001, 16'hC000};

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic busy, cs_n, rc, valid, ovr, tmo;
  logic [15:0] bus;
  logic signed [15:0] smp;
  logic [15:0] scnt, ocnt;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .busy_i(busy), .data_i(bus),
    .cs_no(cs_n), .rc_o(rc), .valid_o(valid), .sample_o(smp),
    .sample_cnt_o(scnt), .overrun_o(ovr), .overrun_cnt_o(ocnt), .timeout_o(tmo));

  // behavioural converter
  logic conv, prev_cs, restart_err;
  logic [15:0] word, code_next;
  int cc, low_cnt, n_conv;
  bit stuck = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1; conv <= 1'b0; prev_cs <= 1'b1; cc <= 0;
      low_cnt <= 0; restart_err <= 1'b0; n_conv <= 0; word <= 16'h0;
    end else begin
      prev_cs <= cs_n;
      if (!conv && prev_cs && !cs_n && !rc && !stuck) begin
        conv <= 1'b1; busy <= 1'b0; cc <= 0; n_conv <= n_conv + 1;
      end else if (conv) begin
        if (cc == CONV_CYC - 1) begin
          conv <= 1'b0; busy <= 1'b1; word <= code_next;
        end else cc <= cc + 1;
      end
      if (!conv && !stuck && !cs_n && !rc) begin
        low_cnt <= low_cnt + 1;
        if (low_cnt >= 12) restart_err <= 1'b1;
      end else low_cnt <= 0;
    end
  end

  assign bus = (!cs_n && rc && !conv) ? word : 16'hBEEF;

  // line-order monitor
  logic m_cs = 1'b1, m_rc = 1'b1;
  bit order_err = 1'b0;
  always @(negedge clk) begin
    if (m_cs && !cs_n && (rc || m_rc)) order_err = 1'b1;
    if (m_rc && !rc && !cs_n) order_err = 1'b1;
    m_cs = cs_n; m_rc = rc;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic pulse_req();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_valid(output bit seen, output int cyc);
    seen = 1'b0; cyc = 0;
    while (!seen && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      if (valid) seen = 1'b1;
    end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    bit seen;
    int cyc;
    int conv0;
    code_next = 16'h0;
    repeat (3) @(negedge clk);
    chk(cs_n && rc, "R1", "lines in reset", {cs_n, rc}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && !ovr && !tmo, "R1", "pulses after reset", {valid, ovr, tmo}, 0);
    chk(scnt == 0 && ocnt == 0, "R1", "counters after reset", {scnt, ocnt}, 0);

    // table-driven samples
    for (int i = 0; i < NVEC; i++) begin
      code_next = VEC[i];
      pulse_req();
      chk(!rc && cs_n, "R2", "convert select before strobe", {cs_n, rc}, 2'b10);
      @(negedge clk);
      chk(!cs_n && !rc, "R2", "strobe with convert", {cs_n, rc}, 2'b00);
      wait_valid(seen, cyc);
      chk(seen, "R5", "valid seen", seen, 1);
      chk(smp == VEC[i], "R5", "sample value", smp, VEC[i]);
      chk(smp[15] == VEC[i][15] && (($signed(smp) < 0) == VEC[i][15]), "R10",
          "sign", smp[15], VEC[i][15]);
      chk(cs_n && rc, "R6", "idle at valid", {cs_n, rc}, 2'b11);
      chk(scnt == 16'(i + 1), "R7", "sample count", scnt, i + 1);
      @(negedge clk);
      chk(!valid, "R6", "valid one cycle", valid, 0);
      chk(scnt == 16'(i + 1), "R7", "count holds", scnt, i + 1);
    end
    chk(!restart_err, "R4", "release window met", restart_err, 0);
    chk(!order_err, "R3", "line ordering", order_err, 0);
    chk(n_conv == NVEC, "R2", "conversions started", n_conv, NVEC);

    // overrun during conversion
    code_next = 16'h4321;
    conv0 = n_conv;
    pulse_req();
    repeat (10) @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(ovr, "R8", "overrun pulse", ovr, 1);
    chk(ocnt == 1, "R8", "overrun count", ocnt, 1);
    @(negedge clk);
    chk(!ovr, "R8", "overrun one cycle", ovr, 0);
    wait_valid(seen, cyc);
    chk(seen && smp == 16'h4321, "R8", "sequence unaffected", smp, 16'h4321);
    repeat (20) @(negedge clk);
    chk(n_conv == conv0 + 1, "R8", "no extra conversion", n_conv, conv0 + 1);
    chk(scnt == NVEC + 1, "R8", "single sample", scnt, NVEC + 1);

    // timeout with an unresponsive converter
    stuck = 1'b1;
    pulse_req();
    cyc = 1; seen = 1'b0;
    while (!seen && cyc < 1000) begin
      if (valid) chk(0, "R9", "valid during timeout", 1, 0);
      @(negedge clk);
      cyc++;
      if (tmo) seen = 1'b1;
    end
    chk(seen, "R9", "timeout pulse", seen, 1);
    chk(cyc >= TMO - 5 && cyc <= TMO + 10, "R9", "timeout latency", cyc, TMO + 2);
    chk(cs_n && rc, "R9", "lines released", {cs_n, rc}, 2'b11);
    @(negedge clk);
    chk(!tmo, "R9", "timeout one cycle", tmo, 0);
    chk(scnt == NVEC + 1, "R9", "no sample on timeout", scnt, NVEC + 1);
    stuck = 1'b0;

    // recovery after timeout
    code_next = 16'h8001;
    pulse_req();
    wait_valid(seen, cyc);
    chk(seen && smp == 16'h8001, "R5", "sample after timeout", smp, 16'h8001);
    chk($signed(smp) == -32767, "R10", "signed value", $signed(smp), -32767);

    // reset in the middle of a conversion
    pulse_req();
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n && rc && scnt == 0 && ocnt == 0, "R1", "mid-run reset",
        {cs_n, rc, scnt, ocnt}, {2'b11, 32'h0});
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule